// File: doc/BRIEF.md
# Byte Serial-Peripheral Master with Status Flags

This block is an SPI master that moves one byte per transfer. A host writes a byte to the data register. The block shifts it out MSB first on `mosi` and collects eight bits from `miso` into a receive buffer. The serial clock `sck` is a division of the system clock. The division is picked by two rate bits in the control register and a double-speed bit in the status register. Only one clock polarity and phase is built: `sck` idles low, input bits are sampled on the rising edge, and output bits change on the falling edge.

Three events are reported through the status register. A finished transfer sets the completion flag. A data write while busy sets the collision flag. A low level on the select input, when that check is enabled, is a mode fault: it also sets the completion flag and stops the shift at once. An interrupt request follows the completion flag, gated by a local enable and a global enable input. The completion flag clears on an acknowledge pulse. Both flags also clear through a two-step sequence: first a status read that sees a flag set, then any access to the data register.

The host port is a plain synchronous register port with a 2-bit address. Address 0 is control, 1 is status, 2 is data, and 3 reads as zero. Read data is combinational from the addressed register.

Top module: `spi_byte_master`

## Requirements
- R1: After reset, `sck`, `mosi` and `irq` are low, and control (address 0) and status (address 1) both read 0x00.
- R2: The transfer clock divider is selected by {status bit 0, control bit 1, control bit 0}: 000=4, 001=16, 010=64, 011=128, 100=2, 101=8, 110=32, 111=64 system clocks per `sck` period. A transfer takes 8 `sck` periods. The setting is taken when the transfer starts.
- R3: `sck` idles low and completes 8 pulses per transfer. `mosi` carries the written byte MSB first and changes only on falling `sck` edges. `miso` is sampled on rising edges. `mosi` is low when idle.
- R4: At the end of a transfer, status bit 7 (completion) is set and the received byte reads back at address 2.
- R5: `irq` is high exactly when status bit 7, control bit 7 (interrupt enable) and the `gie` input are all set.
- R6: A one-cycle `irq_ack` pulse clears status bit 7.
- R7: Status bit 7 clears when a status read sees it set and a later read or write of address 2 follows. A data access with no such prior status read leaves the flag set.
- R8: A write to address 2 during a transfer sets status bit 6 (collision). The written byte is discarded and the running transfer continues unchanged. A status read that sees bit 6 set, followed by a data access, clears bits 6 and 7.
- R9: With control bits 6, 4 and 3 set (enable, master, select check), a low `ss_n` sets status bit 7, aborts any transfer and returns `sck` low. With control bit 3 clear, `ss_n` has no effect.
- R10: A data write starts a transfer only when control bit 6 (enable) and bit 4 (master) are both set. Otherwise it is ignored and `sck` stays low. Clearing either bit stops a running transfer.
- R11: Status bits 5 to 1 always read 0. Status bit 0 is writable and reads back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register address: 0 control, 1 status, 2 data |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (drives the clear sequence) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | input | 1 | Select input watched for mode faults |

## Verification
Several rules are checked on every cycle. `sck` is low whenever no transfer runs or the block is not enabled as master. `mosi` holds still except on falling `sck` edges. A mode fault stops the shift and sets the flag on the next cycle. An acknowledge clears the flag. A busy-time write always raises the collision flag. Some behaviour can only be shown by the bench's reference model and scenarios: the exact divider for each of the eight settings, the received byte, that the two-step clear sequence works only in order, and that a discarded write leaves the outgoing bits untouched.

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int CNT_W = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       gie,
  input  logic       irq_ack,
  output logic       irq,
  output logic       sck,
  output logic       mosi,
  input  logic       miso,
  input  logic       ss_n
);
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [7:0] CTRL_MASK = 8'hDB;
  localparam int EDGES = 16;

  logic [7:0]       ctrl;
  logic             dbl;
  logic             spif, wcol, arm_f, arm_w;
  logic             busy;
  logic [CNT_W-1:0] half_m1, half_sel, dcnt;
  logic [3:0]       ecnt;
  logic [7:0]       txsh, rxsh, rxbuf;

  wire ctl_ie  = ctrl[7];
  wire ctl_en  = ctrl[6];
  wire ctl_ms  = ctrl[4];
  wire ctl_ssc = ctrl[3];
  wire run_cfg = ctl_en & ctl_ms;

  wire [7:0] ctrl_nxt = (wr_en && addr == A_CTRL) ? (wdata & CTRL_MASK) : ctrl;
  wire run_ok  = ctrl_nxt[6] & ctrl_nxt[4];
  wire fault   = run_cfg & ctl_ssc & ~ss_n;
  wire dat_wr  = wr_en && addr == A_DATA;
  wire dat_acc = (wr_en || rd_en) && addr == A_DATA;
  wire st_rd   = rd_en && addr == A_STAT;
  wire tick    = busy && dcnt == half_m1;
  wire last    = tick && ecnt == 4'(EDGES - 1);
  wire start   = dat_wr && !busy && run_cfg && !fault;
  wire collide = dat_wr && busy;
  wire done    = last && run_ok && !fault;

  always_comb begin
    case ({dbl, ctrl[1:0]})
      3'b000:  half_sel = CNT_W'(1);
      3'b001:  half_sel = CNT_W'(7);
      3'b010:  half_sel = CNT_W'(31);
      3'b011:  half_sel = CNT_W'(63);
      3'b100:  half_sel = CNT_W'(0);
      3'b101:  half_sel = CNT_W'(3);
      3'b110:  half_sel = CNT_W'(15);
      default: half_sel = CNT_W'(31);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      sck     <= 1'b0;
      dcnt    <= '0;
      ecnt    <= '0;
      half_m1 <= '0;
      txsh    <= '0;
      rxsh    <= '0;
      rxbuf   <= '0;
    end else if (fault || !run_ok) begin
      busy <= 1'b0;
      sck  <= 1'b0;
    end else if (start) begin
      busy    <= 1'b1;
      sck     <= 1'b0;
      dcnt    <= '0;
      ecnt    <= '0;
      half_m1 <= half_sel;
      txsh    <= wdata;
    end else if (tick) begin
      dcnt <= '0;
      sck  <= ~sck;
      ecnt <= ecnt + 4'd1;
      if (sck) txsh <= {txsh[6:0], 1'b0};
      else     rxsh <= {rxsh[6:0], miso};
      if (last) begin
        busy  <= 1'b0;
        rxbuf <= rxsh;
      end
    end else if (busy) begin
      dcnt <= dcnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl  <= '0;
      dbl   <= 1'b0;
      spif  <= 1'b0;
      wcol  <= 1'b0;
      arm_f <= 1'b0;
      arm_w <= 1'b0;
    end else begin
      ctrl <= ctrl_nxt;
      if (wr_en && addr == A_STAT) dbl <= wdata[0];

      if (done || fault)                   spif <= 1'b1;
      else if (irq_ack)                    spif <= 1'b0;
      else if (dat_acc && (arm_f || arm_w)) spif <= 1'b0;

      if (collide)               wcol <= 1'b1;
      else if (dat_acc && arm_w) wcol <= 1'b0;

      if (dat_acc) begin
        arm_f <= 1'b0;
        arm_w <= 1'b0;
      end else if (st_rd) begin
        if (spif) arm_f <= 1'b1;
        if (wcol) arm_w <= 1'b1;
      end
    end
  end

  assign mosi = busy & txsh[7];
  assign irq  = spif & ctl_ie & gie;

  always_comb begin
    case (addr)
      A_CTRL:  rdata = ctrl;
      A_STAT:  rdata = {spif, wcol, 5'b0, dbl};
      A_DATA:  rdata = rxbuf;
      default: rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/spi_byte_master_chk.sv
module spi_byte_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sck,
  input logic       mosi,
  input logic       irq,
  input logic       gie,
  input logic       irq_ack,
  input logic       wr_en,
  input logic [1:0] addr,
  input logic       busy,
  input logic       spif,
  input logic       wcol,
  input logic       fault,
  input logic       run_cfg
);
  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sck);

  a_r3_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$fell(sck) |-> $stable(mosi));

  a_r4_end_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && run_cfg |-> spif);

  a_r5_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> spif && gie);

  a_r6_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack && !busy && !fault |=> !spif);

  a_r8_busy_write_collides: assert property (@(posedge clk) disable iff (!rst_n)
    busy && wr_en && addr == 2'd2 |=> wcol);

  a_r9_fault_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !busy && !sck && spif);

  a_r10_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
    !run_cfg |-> !busy && !sck);
endmodule

bind spi_byte_master spi_byte_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .mosi(mosi), .irq(irq), .gie(gie),
  .irq_ack(irq_ack), .wr_en(wr_en), .addr(addr), .busy(busy), .spif(spif),
  .wcol(wcol), .fault(fault), .run_cfg(run_cfg)
);

// File: tb/tb_spi_byte_master.sv
`timescale 1ns/1ps
module tb_spi_byte_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = 2'd0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic       gie = 1'b0, irq_ack = 1'b0, irq, sck, mosi;
  logic       miso = 1'b0, ss_n = 1'b1;

  int errors = 0;
  int checks = 0;
  bit done_run = 1'b0;

  always #2 clk = ~clk;

  spi_byte_master dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .gie(gie), .irq_ack(irq_ack), .irq(irq),
    .sck(sck), .mosi(mosi), .miso(miso), .ss_n(ss_n)
  );

  // reference model state
  logic [7:0] m_ctrl, m_tx, m_rdbuf, sb, sb_cur;
  logic m_dbl, m_spif, m_wcol, m_armf, m_armw, m_busy;
  int m_t, m_H;

  function automatic int div_of(logic [2:0] s);
    case (s)
      3'b000: return 4;   3'b001: return 16;
      3'b010: return 64;  3'b011: return 128;
      3'b100: return 2;   3'b101: return 8;
      3'b110: return 32;  default: return 64;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ctrl = 0; m_tx = 0; m_rdbuf = 0; m_dbl = 0; m_spif = 0; m_wcol = 0;
      m_armf = 0; m_armw = 0; m_busy = 0; m_t = 0; m_H = 1; sb_cur = 0;
    end else begin
      logic ofault, obusy, ospif, owcol, oarmf, oarmw, fin, dacc;
      logic [7:0] nctrl;
      ofault = m_ctrl[6] & m_ctrl[4] & m_ctrl[3] & ~ss_n;
      obusy = m_busy; ospif = m_spif; owcol = m_wcol; oarmf = m_armf; oarmw = m_armw;
      nctrl = (wr_en && addr == 2'd0) ? (wdata & 8'hDB) : m_ctrl;
      fin = 0;
      if (ofault) m_busy = 0;
      else if (!(nctrl[6] && nctrl[4])) m_busy = 0;
      else if (m_busy) begin
        m_t++;
        if (m_t == 16 * m_H) begin m_busy = 0; fin = 1; m_rdbuf = sb_cur; end
      end else if (wr_en && addr == 2'd2 && m_ctrl[6] && m_ctrl[4]) begin
        m_busy = 1; m_t = 0; m_H = div_of({m_dbl, m_ctrl[1:0]}) / 2;
        m_tx = wdata; sb_cur = sb;
      end
      dacc = (wr_en || rd_en) && addr == 2'd2;
      if (ofault || fin) m_spif = 1;
      else if (irq_ack) m_spif = 0;
      else if (dacc && (oarmf || oarmw)) m_spif = 0;
      if (wr_en && addr == 2'd2 && obusy) m_wcol = 1;
      else if (dacc && oarmw) m_wcol = 0;
      if (dacc) begin m_armf = 0; m_armw = 0; end
      else if (rd_en && addr == 2'd1) begin
        if (ospif) m_armf = 1;
        if (owcol) m_armw = 1;
      end
      if (wr_en && addr == 2'd1) m_dbl = wdata[0];
      m_ctrl = nctrl;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison of the serial outputs and the interrupt
  always @(posedge clk) begin
    #1;
    if (rst_n && !done_run) begin
      logic e_sck, e_mosi;
      e_sck = m_busy ? logic'((m_t / m_H) % 2) : 1'b0;
      e_mosi = m_busy ? m_tx[7 - (m_t / (2 * m_H))] : 1'b0;
      chk("R2/R3 sck", sck, e_sck);
      chk("R3 mosi", mosi, e_mosi);
      chk("R5 irq", irq, m_spif & m_ctrl[7] & gie);
    end
  end

  // slave response: present the next bit after each falling edge
  always @(negedge clk) miso = m_busy ? sb_cur[7 - (m_t / (2 * m_H))] : 1'b0;

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, logic [7:0] exp, string tag);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 chk(tag, rdata, exp);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_done();
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic ack();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R4 watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    sb = 8'h00;
    idle(3);
    chk("R1 sck", sck, 0); chk("R1 mosi", mosi, 0); chk("R1 irq", irq, 0);
    rst_n = 1'b1;
    rd(2'd0, 8'h00, "R1 ctrl");
    rd(2'd1, 8'h00, "R1 status");

    // R11: reserved status bits
    wr(2'd1, 8'hFF);
    rd(2'd1, 8'h01, "R11 status rw");
    wr(2'd1, 8'h00);
    rd(2'd1, 8'h00, "R11 status cleared");

    // R2 R3 R4 R7: every divider setting
    gie = 1'b1;
    for (int s = 0; s < 8; s++) begin
      int n;
      logic [7:0] txb;
      wr(2'd1, {7'b0, s[2]});
      wr(2'd0, 8'hD0 | {6'b0, s[1:0]});
      txb = 8'hA5 + 8'(s * 17);
      sb = 8'h3C ^ 8'(s * 29);
      wr(2'd2, txb);
      n = 0;
      while (!irq && n < 3000) begin @(negedge clk); n++; end
      chk("R2 transfer length", n, 8 * div_of(3'(s)));
      rd(2'd1, {1'b1, 6'b0, s[2]}, "R4 flag set");
      rd(2'd2, sb, "R4 received byte");
      rd(2'd1, {7'b0, s[2]}, "R7 flag cleared by sequence");
    end
    wr(2'd1, 8'h00);
    wr(2'd0, 8'hD0);

    // R7 negative, then R6 acknowledge
    sb = 8'h5A;
    wr(2'd2, 8'h81);
    wait_done();
    rd(2'd2, 8'h5A, "R7 data read alone");
    rd(2'd0, 8'hD0, "R7 ctrl");
    rd(2'd1, 8'h80, "R7 flag kept without status read");
    chk("R5 irq high", irq, 1);
    ack();
    rd(2'd1, 8'h00, "R6 ack clears");
    chk("R6 irq low", irq, 0);

    // R5 gating
    gie = 1'b0;
    sb = 8'hC3;
    wr(2'd2, 8'h7E);
    wait_done();
    chk("R5 gie masks", irq, 0);
    rd(2'd1, 8'h80, "R5 flag set while masked");
    gie = 1'b1;
    @(negedge clk); chk("R5 gie unmask", irq, 1);
    wr(2'd0, 8'h50);
    chk("R5 ie masks", irq, 0);
    wr(2'd0, 8'hD0);
    ack();

    // R8 collision
    sb = 8'h96;
    wr(2'd2, 8'hB4);
    idle(5);
    wr(2'd2, 8'hFF);
    rd(2'd1, 8'h40, "R8 collision flag");
    wait_done();
    rd(2'd1, 8'hC0, "R8 both flags");
    rd(2'd2, 8'h96, "R8 transfer unaffected");
    rd(2'd1, 8'h00, "R8 both cleared");

    // R9 mode fault
    wr(2'd0, 8'hD8);
    sb = 8'h11;
    wr(2'd2, 8'hE7);
    idle(10);
    @(negedge clk); ss_n = 1'b0;
    @(negedge clk); ss_n = 1'b1;
    chk("R9 sck low after fault", sck, 0);
    rd(2'd1, 8'h80, "R9 fault sets flag");
    idle(40);
    rd(2'd1, 8'h80, "R9 no resumed transfer");
    ack();
    wr(2'd0, 8'hD0);
    sb = 8'h2D;
    wr(2'd2, 8'h4B);
    idle(6);
    @(negedge clk); ss_n = 1'b0;
    wait_done();
    ss_n = 1'b1;
    rd(2'd2, 8'h2D, "R9 select ignored when check off");
    ack();

    // R10 enable and master needed
    wr(2'd0, 8'hC0);
    wr(2'd2, 8'h99);
    idle(40);
    rd(2'd1, 8'h00, "R10 no transfer without master");
    chk("R10 sck idle", sck, 0);
    wr(2'd0, 8'h10);
    wr(2'd2, 8'h99);
    idle(40);
    rd(2'd1, 8'h00, "R10 no transfer without enable");
    wr(2'd0, 8'hD0);
    sb = 8'h0F;
    wr(2'd2, 8'hAA);
    idle(8);
    wr(2'd0, 8'h80);
    idle(2);
    chk("R10 stop sck", sck, 0);
    rd(2'd1, 8'h00, "R10 stop without flag");

    done_run = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule